// File: doc/BRIEF.md
# Sensitivity Taint Propagation Tracker

This block is a shadow state that runs alongside a small machine. It holds one secrecy bit for each register or memory location of that machine. It does not model data values or instruction decoding. Each cycle the machine reports the operation that just executed: up to two source location identifiers with a per-operand used mask, one destination identifier and a write strobe. On the closing clock edge the tracker recomputes the destination's bit from the bits its sources held before that edge. A secret operand makes the result secret. A result built only from public operands or constants is public.

At reset the four locations that hold the cryptographic key are marked secret and every other location is public. A host port can force any single location's bit to either value, and a host write takes priority over a propagation update to the same location. The whole bit vector is available on a registered output every cycle. Logging that output shows how secrecy spreads from the key storage through the machine over time.

Top module: `taint_tracker`

## Requirements
- R1: While `rst` is high, `tag_vec` becomes secret (1) at indices KEY_BASE through KEY_BASE+KEY_COUNT-1 and public (0) everywhere else. The defaults are indices 0..3 of 32 locations, giving `tag_vec` = 0x0000000F.
- R2: With `dst_we` high, if any operand whose `src_used` bit is set names a location whose tag is 1, `tag_vec[dst_id]` is 1 after the next rising edge. Bit k of `src_used` qualifies operand k, and operand k sits in `src_ids[k*ID_W +: ID_W]`.
- R3: With `dst_we` high, if every used operand names a public location, or if no operand is used (a constant or immediate), `tag_vec[dst_id]` becomes 0 after the next edge.
- R4: An operand whose `src_used` bit is 0 has no effect on the result, even when it names a secret location.
- R5: With `dst_we` low and `host_wr` low, `tag_vec` does not change.
- R6: A propagation update changes only the destination bit. One edge changes at most two bits (the destination and the host target).
- R7: With `host_wr` high, `tag_vec[host_id]` equals `host_tag` after the next edge.
- R8: When `host_wr` and `dst_we` target the same location in one cycle, the host value is the one stored.
- R9: Operands read the tags held before the edge. A destination that is also its own source keeps its old value. A location written in one cycle passes its new tag to an operation in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dst_we | input | 1 | The executed operation wrote a destination |
| dst_id | input | ID_W | Destination location |
| src_ids | input | NUM_SRC*ID_W | Packed operand locations, operand k at bits k*ID_W |
| src_used | input | NUM_SRC | Per-operand valid mask |
| host_wr | input | 1 | Host forces one tag |
| host_id | input | ID_W | Host target location |
| host_tag | input | 1 | Value forced by the host |
| tag_vec | output | NUM_LOC | Registered snapshot of all tags |

## Verification
The bench first drives directed operations: two secret operands, one secret and one public operand, all-public operands, constant-only writes, and a secret operand hidden behind a cleared used bit. Together these distinguish an OR merge from an AND merge, or from a merge that ignores the mask. Writes without a strobe, and host writes that collide with a propagation update, separate "no change" from "clear" and establish which writer has priority. Self-referencing and chained operations show whether operands see the old tags or the new ones. A long pseudo-random run then mixes all of these cases, comparing the whole snapshot on every cycle.

// File: rtl/taint_pkg.sv
package taint_pkg;
  typedef enum logic {
    TAG_PUBLIC = 1'b0,
    TAG_SECRET = 1'b1
  } tag_e;
endpackage

// File: rtl/taint_src_merge.sv
module taint_src_merge #(
  parameter int NUM_LOC = 32,
  parameter int NUM_SRC = 2,
  parameter int ID_W    = $clog2(NUM_LOC)
) (
  input  logic [NUM_LOC-1:0]      tags,
  input  logic [NUM_SRC*ID_W-1:0] src_ids,
  input  logic [NUM_SRC-1:0]      src_used,
  output logic                    src_hot
);
  localparam logic [ID_W:0] LOC_LIMIT = (ID_W+1)'(NUM_LOC);

  logic [NUM_SRC-1:0] per_src;

  // One lookup per operand; unused or out-of-range operands read as public.
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [ID_W-1:0] id_k;
    assign id_k = src_ids[k*ID_W +: ID_W];
    always_comb begin
      per_src[k] = 1'b0;
      if (src_used[k] && ({1'b0, id_k} < LOC_LIMIT))
        per_src[k] = tags[id_k];
    end
  end

  assign src_hot = |per_src;
endmodule

// File: rtl/taint_next_state.sv
module taint_next_state
  import taint_pkg::*;
#(
  parameter int NUM_LOC = 32,
  parameter int ID_W    = $clog2(NUM_LOC)
) (
  input  logic [NUM_LOC-1:0] cur,
  input  logic               dst_we,
  input  logic [ID_W-1:0]    dst_id,
  input  logic               src_hot,
  input  logic               host_wr,
  input  logic [ID_W-1:0]    host_id,
  input  tag_e               host_tag,
  output logic [NUM_LOC-1:0] nxt
);
  // Per-location select: host write, then propagation, then hold.
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic host_hit;
    logic prop_hit;
    assign host_hit = host_wr && (host_id == ID_W'(i));
    assign prop_hit = dst_we && (dst_id == ID_W'(i));
    always_comb begin
      if (host_hit)      nxt[i] = (host_tag == TAG_SECRET);
      else if (prop_hit) nxt[i] = src_hot;
      else               nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/taint_tracker.sv
module taint_tracker
  import taint_pkg::*;
#(
  parameter int NUM_LOC   = 32,
  parameter int NUM_SRC   = 2,
  parameter int KEY_BASE  = 0,
  parameter int KEY_COUNT = 4,
  parameter int ID_W      = $clog2(NUM_LOC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dst_we,
  input  logic [ID_W-1:0]         dst_id,
  input  logic [NUM_SRC*ID_W-1:0] src_ids,
  input  logic [NUM_SRC-1:0]      src_used,
  input  logic                    host_wr,
  input  logic [ID_W-1:0]         host_id,
  input  logic                    host_tag,
  output logic [NUM_LOC-1:0]      tag_vec
);
  logic [NUM_LOC-1:0] key_mask;
  logic [NUM_LOC-1:0] tag_q;
  logic [NUM_LOC-1:0] tag_d;
  logic               src_hot;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_key
    assign key_mask[i] = (i >= KEY_BASE) && (i < KEY_BASE + KEY_COUNT);
  end

  taint_src_merge #(
    .NUM_LOC (NUM_LOC),
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W)
  ) u_merge (
    .tags     (tag_q),
    .src_ids  (src_ids),
    .src_used (src_used),
    .src_hot  (src_hot)
  );

  taint_next_state #(
    .NUM_LOC (NUM_LOC),
    .ID_W    (ID_W)
  ) u_next (
    .cur      (tag_q),
    .dst_we   (dst_we),
    .dst_id   (dst_id),
    .src_hot  (src_hot),
    .host_wr  (host_wr),
    .host_id  (host_id),
    .host_tag (tag_e'(host_tag)),
    .nxt      (tag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) tag_q <= key_mask;
    else     tag_q <= tag_d;
  end

  assign tag_vec = tag_q;

  // R1: reset loads the key-only pattern
  assert_reset_keys_R1: assert property (@(posedge clk)
    rst |=> (tag_q == key_mask));

  // R2: a secret used operand marks the destination
  assert_src_to_dst_R2: assert property (@(posedge clk) disable iff (rst)
    (dst_we && src_hot && !(host_wr && host_id == dst_id))
      |=> tag_q[$past(dst_id)]);

  // R3: all-public operands clear the destination
  assert_public_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (dst_we && !src_hot && !(host_wr && host_id == dst_id))
      |=> !tag_q[$past(dst_id)]);

  // R5: idle cycles keep every tag
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!dst_we && !host_wr) |=> $stable(tag_q));

  // R6: at most two bits move per edge
  assert_local_change_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(tag_q ^ $past(tag_q)) <= 2));

  // R7, R8: host value lands, including on collisions
  assert_host_wins_R8: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (tag_q[$past(host_id)] == $past(host_tag)));
endmodule

// File: tb/sim_taint_tracker.sv
`timescale 1ns/1ps
module sim_taint_tracker;
  localparam int N    = 32;
  localparam int IDW  = 5;
  localparam int NSRC = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            dst_we = 1'b0;
  logic [IDW-1:0]  dst_id = '0;
  logic [NSRC*IDW-1:0] src_ids = '0;
  logic [NSRC-1:0] src_used = '0;
  logic            host_wr = 1'b0;
  logic [IDW-1:0]  host_id = '0;
  logic            host_tag = 1'b0;
  logic [N-1:0]    tag_vec;

  int checks = 0;
  int fails  = 0;
  bit ref_tags [N];

  always #2.5 clk = ~clk;

  taint_tracker u0 (
    .clk(clk), .rst(rst), .dst_we(dst_we), .dst_id(dst_id),
    .src_ids(src_ids), .src_used(src_used), .host_wr(host_wr),
    .host_id(host_id), .host_tag(host_tag), .tag_vec(tag_vec)
  );

  function automatic logic [N-1:0] ref_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ref_tags[i];
    return v;
  endfunction

  task automatic compare(string req);
    checks++;
    if (tag_vec !== ref_vec()) begin
      fails++;
      $display("FAIL %s: tag_vec actual=%h expected=%h", req, tag_vec, ref_vec());
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; dst_we = 1'b0; host_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) ref_tags[i] = (i < 4);
    compare("R1 reset pattern");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one cycle at a negedge, predict, compare after the edge.
  task automatic step(bit we, int d, int s0, int s1, bit [1:0] used,
                      bit hw, int hid, bit htag, string req);
    bit hot;
    dst_we = we; dst_id = IDW'(d);
    src_ids = {IDW'(s1), IDW'(s0)}; src_used = used;
    host_wr = hw; host_id = IDW'(hid); host_tag = htag;
    hot = (used[0] && ref_tags[s0]) || (used[1] && ref_tags[s1]);
    if (we) ref_tags[d] = hot;
    if (hw) ref_tags[hid] = htag;
    @(posedge clk);
    #1;
    compare(req);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(1, 8, 0, 9, 2'b11, 0, 0, 0, "R2 secret plus public operand");
    step(1, 9, 1, 2, 2'b11, 0, 0, 0, "R2 two secret operands");
    step(1, 8, 10, 11, 2'b11, 0, 0, 0, "R3 public operands clear");
    step(1, 12, 0, 5, 2'b01, 0, 0, 0, "R2 single used operand");
    step(1, 12, 1, 20, 2'b10, 0, 0, 0, "R4 unused secret operand ignored");
    step(1, 9, 0, 1, 2'b00, 0, 0, 0, "R3 constant operands clear");
    step(0, 5, 0, 1, 2'b11, 0, 0, 0, "R5 no write strobe");
    step(1, 2, 20, 21, 2'b11, 0, 0, 0, "R6 key bit cleared, others held");
    step(0, 0, 0, 0, 2'b00, 1, 30, 1, "R7 host sets");
    step(0, 0, 0, 0, 2'b00, 1, 0, 0, "R7 host clears");
    step(1, 15, 1, 1, 2'b11, 1, 15, 0, "R8 host clear beats propagation");
    step(1, 16, 20, 21, 2'b11, 1, 16, 1, "R8 host set beats propagation");
    step(1, 3, 3, 22, 2'b11, 0, 0, 0, "R9 self reference keeps tag");
    step(1, 17, 3, 22, 2'b01, 0, 0, 0, "R9 chain first hop");
    step(1, 18, 17, 23, 2'b01, 0, 0, 0, "R9 chain sees new tag");
    step(1, 17, 24, 25, 2'b11, 1, 26, 1, "R6 destination and host both move");
    for (int n = 0; n < 400; n++) begin
      bit we = 1'($urandom_range(0, 3) != 0);
      bit hw = 1'($urandom_range(0, 5) == 0);
      step(we, $urandom_range(0, N-1), $urandom_range(0, N-1),
           $urandom_range(0, N-1), 2'($urandom_range(0, 3)),
           hw, $urandom_range(0, N-1), 1'($urandom_range(0, 1)),
           "R2 R3 R4 R8 random mix");
    end
    do_reset();
    step(1, 10, 3, 4, 2'b11, 0, 0, 0, "R2 after second reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule